// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial slave engine of a byte-addressed non-volatile memory. When a write transaction opens it takes the base address. It then gathers each incoming data byte into a page-sized holding buffer, placing bytes at successive offsets within one page. Nothing reaches the array while the transaction is still running. When the transaction closes with a stop, the buffered bytes are copied into the array. This copy runs inside a self-timed programming interval. During that interval the block raises a busy flag, and the slave engine uses it to ignore the bus completely.

Each slot of the buffer carries a valid flag, so only the locations that actually received data are written during the commit. A new start that arrives before the stop throws the buffer away. So does an explicit abort. A stop with an empty buffer closes the transaction without starting a programming interval. Bytes that the engine refuses because write protection is on are not kept.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the buffer holds no valid bytes.
- R2: A byte accepted during an open transaction is stored at the current page offset. The first byte goes to the offset given by the low 5 bits of `wr_addr` at `wr_start`. Each accepted byte advances the offset by one.
- R3: The offset wraps from 31 to 0. The page, which is `wr_addr` bits 12 to 5 at `wr_start`, never changes within a transaction.
- R4: A later byte that lands on an already filled offset replaces the earlier value.
- R5: `mem_we` stays low until a stop. A `stop_stb` during an open transaction with at least one valid byte raises `busy` on the following cycle. `busy` then stays high for exactly PROG_CYCLES clocks, and the buffer is emptied when it falls.
- R6: Commit writes happen during busy cycle k, for k from 0 to 31. In cycle k, `mem_we` is high exactly when offset k is valid, with `mem_addr` = {page, k} and `mem_wdata` equal to the stored byte. This gives ascending offsets, with each valid offset written exactly once.
- R7: A stop with no valid byte in the buffer closes the transaction. It starts no busy interval and no write.
- R8: `abort_stb` during an open transaction discards the buffer and closes the transaction. A `wr_start` during an open transaction discards the buffer and opens a new transaction at the new address. Priority is `wr_start`, then `abort_stb`, then `stop_stb`, then `byte_stb`.
- R9: A byte strobe with `wc_hold` high is neither stored nor committed, and it does not advance the offset.
- R10: While `busy` is high, every input strobe is ignored. After `busy` falls, a new transaction is accepted normally.
- R11: Byte and stop strobes outside an open transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Opens a write transaction, one-cycle strobe |
| wr_addr | input | ADDR_W | Base address sampled with `wr_start` |
| wc_hold | input | 1 | Write protection active; qualifies `byte_stb` |
| byte_stb | input | 1 | One data byte received |
| byte_data | input | DATA_W | Data byte that goes with `byte_stb` |
| stop_stb | input | 1 | Transaction ended by stop |
| abort_stb | input | 1 | Transaction abandoned |
| mem_we | output | 1 | Array write enable, one byte per cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming interval running; bus must be ignored |

## Verification
The assertions take for granted that every strobe lasts a single clock. They also assume that PROG_CYCLES is larger than the page size, so the commit scan always finishes before busy drops. The stimulus drives every strobe for exactly one cycle, changing the inputs on the falling edge. It does assert strobes while busy is high, because R10 requires that case to be covered. It never opens a transaction with the parameters outside their stated bounds.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_FILL = 2'd1,
    PG_PROG = 2'd2
  } pg_state_e;

  // Offset advance inside a power-of-two page: wraps to zero at the end.
  function automatic int unsigned pg_wrap_inc(input int unsigned off,
                                              input int unsigned page);
    return (off + 1) % page;
  endfunction

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] load_off_i,
  input  logic                          store_i,
  input  logic [DATA_W-1:0]             store_data_i,
  input  logic                          clear_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_off_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_valid_o,
  output logic                          any_valid_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [OFF_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] valid_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [OFF_W-1:0]      ptr_next;

  assign ptr_next = OFF_W'(pg_wrap_inc(int'(ptr_q), PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      valid_q <= '0;
    end else if (load_i) begin
      ptr_q   <= load_off_i;
      valid_q <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (store_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_next;
    end
  end

  // One data register per page slot; written only when the pointer selects it.
  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (store_i && !load_i && !clear_i && (ptr_q == OFF_W'(gi)))
        slot_q[gi] <= store_data_i;
    end
  end

  assign rd_data_o   = slot_q[rd_off_i];
  assign rd_valid_o  = valid_q[rd_off_i];
  assign any_valid_o = |valid_q;

  // R2: a stored byte marks its slot valid on the next cycle
  p_store_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !load_i && !clear_i) |=> valid_q[$past(ptr_q)]);

  // R8: a load leaves an empty buffer
  p_load_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !any_valid_o);

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          begin_i,
  input  logic                          byte_i,
  input  logic                          hold_i,
  input  logic                          stop_i,
  input  logic                          abort_i,
  input  logic                          any_valid_i,
  output logic                          load_o,
  output logic                          store_o,
  output logic                          clear_o,
  output logic                          busy_o,
  output logic                          scan_live_o,
  output logic [$clog2(PAGE_BYTES)-1:0] scan_off_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_LIVE = CNT_W'(PAGE_BYTES);

  pg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named events for the assertions and the datapath.
  logic in_fill, in_prog;
  logic ev_open, ev_restart, ev_abort, ev_stop, ev_commit, ev_store, ev_prog_end;

  always_comb begin
    in_fill     = (state_q == PG_FILL);
    in_prog     = (state_q == PG_PROG);
    ev_open     = (state_q == PG_IDLE) && begin_i;
    ev_restart  = in_fill && begin_i;
    ev_abort    = in_fill && !begin_i && abort_i;
    ev_stop     = in_fill && !begin_i && !abort_i && stop_i;
    ev_commit   = ev_stop && any_valid_i;
    ev_store    = in_fill && !begin_i && !abort_i && !stop_i && byte_i && !hold_i;
    ev_prog_end = in_prog && (cnt_q == CNT_LAST);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PG_IDLE: if (ev_open) state_d = PG_FILL;
      PG_FILL: begin
        if (ev_abort) state_d = PG_IDLE;
        else if (ev_commit) begin
          state_d = PG_PROG;
          cnt_d   = '0;
        end else if (ev_stop) state_d = PG_IDLE;
      end
      PG_PROG: begin
        if (ev_prog_end) begin
          state_d = PG_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o      = ev_open || ev_restart;
  assign store_o     = ev_store;
  assign clear_o     = ev_abort || ev_prog_end;
  assign busy_o      = in_prog;
  assign scan_live_o = in_prog && (cnt_q < CNT_LIVE);
  assign scan_off_o  = cnt_q[OFF_W-1:0];

  // R5: the busy interval only starts from a stop strobe
  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R5: busy ends only after the full count
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == CNT_LAST));

  // R10: no buffer activity while the programming interval runs
  p_deaf_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!load_o && !store_o));

  // R7: an empty stop never starts programming
  p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !any_valid_i) |=> !busy_o);

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wc_hold,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_stb,
  input  logic              abort_stb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic              load, store, clear, scan_live, rd_valid, any_valid;
  logic [OFF_W-1:0]  scan_off;
  logic [DATA_W-1:0] rd_data;
  logic [PAGE_W-1:0] page_q;

  pgwr_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .begin_i     (wr_start),
    .byte_i      (byte_stb),
    .hold_i      (wc_hold),
    .stop_i      (stop_stb),
    .abort_i     (abort_stb),
    .any_valid_i (any_valid),
    .load_o      (load),
    .store_o     (store),
    .clear_o     (clear),
    .busy_o      (busy),
    .scan_live_o (scan_live),
    .scan_off_o  (scan_off)
  );

  pgwr_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .load_off_i   (wr_addr[OFF_W-1:0]),
    .store_i      (store),
    .store_data_i (byte_data),
    .clear_i      (clear),
    .rd_off_i     (scan_off),
    .rd_data_o    (rd_data),
    .rd_valid_o   (rd_valid),
    .any_valid_o  (any_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    page_q <= '0;
    else if (load) page_q <= wr_addr[ADDR_W-1:OFF_W];
  end

  assign mem_we    = scan_live && rd_valid;
  assign mem_addr  = {page_q, scan_off};
  assign mem_wdata = rd_data;

  // R6: array writes only inside the busy interval
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5: buffer is empty once the interval ends
  p_end_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_valid);

  // R3: page stays fixed across consecutive busy cycles
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));

endmodule

// File: tb/tb_pgwr_commit.sv
module tb_pgwr_commit;
  localparam int AW = 13, DW = 8, PG = 32, PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 0, wc_hold = 0, byte_stb = 0, stop_stb = 0, abort_stb = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #4 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PG), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .wc_hold(wc_hold), .byte_stb(byte_stb), .byte_data(byte_data),
    .stop_stb(stop_stb), .abort_stb(abort_stb), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // Behavioural reference model
  bit m_fill, m_busy;
  int m_cnt, m_page, m_ptr;
  int m_buf[PG];
  bit m_val[PG];
  int dmem[int];

  function automatic bit m_any();
    foreach (m_val[i]) if (m_val[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fill = 0; m_busy = 0; m_cnt = 0; m_ptr = 0; m_page = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (m_busy) begin
      if (m_cnt == PROG - 1) begin
        m_busy = 0; foreach (m_val[i]) m_val[i] = 0;
      end else m_cnt++;
    end else if (m_fill) begin
      if (wr_start) begin
        m_page = int'(wr_addr) / PG; m_ptr = int'(wr_addr) % PG;
        foreach (m_val[i]) m_val[i] = 0;
      end else if (abort_stb) begin
        m_fill = 0; foreach (m_val[i]) m_val[i] = 0;
      end else if (stop_stb) begin
        m_fill = 0;
        if (m_any()) begin m_busy = 1; m_cnt = 0; end
      end else if (byte_stb && !wc_hold) begin
        m_buf[m_ptr] = int'(byte_data); m_val[m_ptr] = 1; m_ptr = (m_ptr + 1) % PG;
      end
    end else if (wr_start) begin
      m_fill = 1; m_page = int'(wr_addr) / PG; m_ptr = int'(wr_addr) % PG;
      foreach (m_val[i]) m_val[i] = 0;
    end
    if (rst_n && mem_we) dmem[int'(mem_addr)] = int'(mem_wdata);
  end

  // Cycle compare on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_we;
      e_we = m_busy && (m_cnt < PG) && m_val[m_cnt % PG];
      checks++;
      if (busy !== m_busy || mem_we !== e_we) begin
        fails++;
        $display("FAIL %s cycle: busy=%0b/%0b we=%0b/%0b (actual/expected)",
                 cur_req, busy, m_busy, mem_we, e_we);
      end else if (e_we && (int'(mem_addr) != m_page * PG + m_cnt ||
                            int'(mem_wdata) != m_buf[m_cnt])) begin
        fails++;
        $display("FAIL %s cycle: addr=%0h data=%0h expected addr=%0h data=%0h",
                 cur_req, mem_addr, mem_wdata, m_page * PG + m_cnt, m_buf[m_cnt]);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rd(int a);
    return dmem.exists(a) ? dmem[a] : -1;
  endfunction

  task automatic t_start(int a);
    wr_start = 1; wr_addr = AW'(a); @(negedge clk); wr_start = 0;
  endtask
  task automatic t_byte(int d, bit h = 0);
    byte_stb = 1; byte_data = DW'(d); wc_hold = h; @(negedge clk); byte_stb = 0; wc_hold = 0;
  endtask
  task automatic t_stop();
    stop_stb = 1; @(negedge clk); stop_stb = 0;
  endtask
  task automatic t_abort();
    abort_stb = 1; @(negedge clk); abort_stb = 0;
  endtask
  task automatic t_drain(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1", int'(busy), 0);
    check("R1", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2";  // single byte at 0x123
    t_start('h123); t_byte('hA5); t_stop();
    t_drain(n);
    check("R5 busy length", n, PROG);
    check("R2", rd('h123), 'hA5);

    cur_req = "R3";  // wrap from offset 30
    t_start('h05E);
    t_byte('h11); t_byte('h22); t_byte('h33); t_byte('h44); t_byte('h55);
    check("R5 no write before stop", dmem.size(), 1);
    t_stop(); t_drain(n);
    check("R3", rd('h05F), 'h22);
    check("R3", rd('h040), 'h33);
    check("R3", rd('h042), 'h55);
    check("R3", rd('h060), -1);

    cur_req = "R4";  // 33 bytes overwrite offset 0
    t_start('h200);
    for (int i = 0; i < 33; i++) t_byte(i + 1);
    t_stop(); t_drain(n);
    check("R4", rd('h200), 33);
    check("R6", rd('h21F), 32);

    cur_req = "R7";
    t_start('h300); t_stop();
    check("R7", int'(busy), 0);
    t_drain(n);
    check("R7", n, 0);

    cur_req = "R8";
    t_start('h400); t_byte('h77); t_abort(); t_stop();
    check("R8", int'(busy), 0);
    t_start('h500); t_byte('h66); t_start('h520); t_byte('h99); t_stop();
    t_drain(n);
    check("R8", rd('h400), -1);
    check("R8", rd('h500), -1);
    check("R8", rd('h520), 'h99);

    cur_req = "R9";
    t_start('h600); t_byte('h01, 1); t_byte('h02); t_stop(); t_drain(n);
    check("R9", rd('h600), 'h02);
    check("R9", rd('h601), -1);
    t_start('h620); t_byte('h03, 1); t_stop();
    check("R9", int'(busy), 0);

    cur_req = "R10";
    t_start('h700); t_byte('hAB); t_stop();
    t_start('h740); t_byte('hCD); t_stop(); t_abort();
    t_drain(n);
    check("R10", n, PROG - 4);
    check("R10", rd('h740), -1);
    t_start('h760); t_byte('hEE); t_stop(); t_drain(n);
    check("R10", rd('h760), 'hEE);
    check("R10", rd('h700), 'hAB);

    cur_req = "R11";
    t_byte('h12); t_stop();
    check("R11", int'(busy), 0);
    t_start('h780); t_stop(); t_drain(n);
    check("R11", rd('h780), -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule